// File: doc/BRIEF.md
# Switcher Protection and Restart Sequencer

This block is the control state machine that decides when the power switch of an offline converter may be driven. It takes digitized comparator results as inputs: supply above the start level, supply below the stop level, supply over-voltage, peak-current limit reached, and die over-temperature. It also takes a millisecond tick, a switching-cycle boundary pulse and a strap that selects latched or self-restarting behaviour on overload. From these it produces the drive enable, a soft-start flag with a rising step count for the current-setpoint ramp, and a latched-off indicator.

The states are ST_WAIT_ON (no drive, waiting for the start level), ST_SOFT (drive with the soft-start ramp running), ST_RUN (normal drive), ST_THERM (drive held off by over-temperature), ST_HIC_DRAIN1 (overload confirmed, waiting for the supply to collapse), ST_HIC_SKIP (supply recharging, where the next start crossing is deliberately ignored), ST_HIC_DRAIN2 (waiting for the second collapse) and ST_LATCH (off until power-on reset). The transitions are: ST_WAIT_ON to ST_SOFT on the start flag. ST_SOFT to ST_RUN when the ramp is full. ST_SOFT or ST_RUN to ST_WAIT_ON on the stop flag, to ST_LATCH or ST_HIC_DRAIN1 on a confirmed overload, and to ST_THERM on over-temperature. ST_THERM to ST_SOFT when the temperature flag clears, or to ST_WAIT_ON on the stop flag. ST_HIC_DRAIN1 to ST_HIC_SKIP on the stop flag. ST_HIC_SKIP to ST_HIC_DRAIN2 on the start flag. ST_HIC_DRAIN2 to ST_WAIT_ON on the stop flag. Any state goes to ST_LATCH on a qualified over-voltage.

The power-on reset input models loss of the hold current that keeps the part latched. It is the only way out of ST_LATCH.

Top module: `pwr_prot_seq`

## Requirements
- R1: From ST_WAIT_ON, a high vcc_start (with vcc_stop low) turns drive_en on in the next cycle. While driving, a high vcc_stop turns drive_en off in the next cycle.
- R2: Every entry to driving from a non-driving state begins with ss_active high and ss_step at 0. Each ms_tick while ss_active raises ss_step by one. After SS_MS ticks ss_step equals SS_MS, and one cycle later ss_active falls while ss_step holds SS_MS. ss_step never exceeds SS_MS.
- R3: While driving, the overload count rises on each ms_tick taken while ilim_hit is high or a hit was seen earlier in the current switching cycle. When the count reaches OVL_MS, drive_en falls one cycle later.
- R4: A cycle_end pulse that closes a switching cycle with no ilim_hit anywhere in it (including the cycle_end cycle) clears the overload count to zero.
- R5: With latch_opt = 1, a confirmed overload sets latched_o and holds drive_en low.
- R6: With latch_opt = 0, a confirmed overload stops drive. The first vcc_start after the following vcc_stop is ignored, with drive_en staying low. Drive resumes with a fresh soft-start only on the vcc_start that follows the second vcc_stop.
- R7: vcc_ovp high on OVP_TICKS consecutive ms_tick samples latches the block from any state, with drive_en low one cycle after the last of those ticks. An ms_tick sampled with vcc_ovp low restarts the run.
- R8: Once latched_o is high, no input except rst_n low clears it or re-enables drive. After reset, a normal startup runs.
- R9: While driving, a high over_temp turns drive_en off in the next cycle. When over_temp returns low, drive resumes one cycle later with a fresh soft-start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low power-on reset; also releases the latch |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| cycle_end | input | 1 | One-cycle pulse at each switching-cycle boundary |
| vcc_start | input | 1 | Supply above the start threshold |
| vcc_stop | input | 1 | Supply below the stop threshold |
| vcc_ovp | input | 1 | Raw supply over-voltage comparator |
| ilim_hit | input | 1 | Peak-current limit reached in this cycle |
| over_temp | input | 1 | Die over-temperature comparator (hysteresis upstream) |
| latch_opt | input | 1 | 1 = latch on overload, 0 = double-hiccup auto-recovery |
| drive_en | output | 1 | Switching permitted |
| ss_active | output | 1 | Soft-start ramp in progress |
| ss_step | output | $clog2(SS_MS+1) | Soft-start step count, saturating at SS_MS |
| latched_o | output | 1 | Latched-off state |

## Verification
The bench builds the block with SS_MS = 4, OVL_MS = 12 and OVP_TICKS = 3. These values reach the ramp saturation, the overload trip and the over-voltage qualification within a few dozen ticks each, so one run can go through the full double-hiccup cycle twice, through latching by both overload and over-voltage, and through recovery by reset. The short overload window also lets random hit, tick and cycle-boundary patterns reach the trip point many times against a count model kept in the bench. Those patterns include windows where a clean cycle clears the count part way.

// File: rtl/psup_pkg.sv
package psup_pkg;

    typedef enum logic [2:0] {
        ST_WAIT_ON    = 3'd0,
        ST_SOFT       = 3'd1,
        ST_RUN        = 3'd2,
        ST_THERM      = 3'd3,
        ST_HIC_DRAIN1 = 3'd4,
        ST_HIC_SKIP   = 3'd5,
        ST_HIC_DRAIN2 = 3'd6,
        ST_LATCH      = 3'd7
    } psup_state_e;

endpackage

// File: rtl/psup_ovl_timer.sv
// Overload qualification: counts millisecond ticks while a current-limit
// hit is present in the running switching cycle; a clean cycle clears it.
module psup_ovl_timer #(
    parameter int LIMIT = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic ms_tick,
    input  logic cycle_end,
    input  logic ilim_hit,
    output logic trip
);
    localparam int OW = $clog2(LIMIT + 1);
    localparam logic [OW-1:0] LIM = OW'(LIMIT);

    logic [OW-1:0] cnt_q;
    logic          hit_q;
    logic          flag;

    assign flag = hit_q | ilim_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            hit_q <= 1'b0;
        end else if (!en) begin
            cnt_q <= '0;
            hit_q <= 1'b0;
        end else begin
            if (cycle_end)
                hit_q <= ilim_hit;
            else if (ilim_hit)
                hit_q <= 1'b1;

            if (cycle_end && !flag)
                cnt_q <= '0;
            else if (ms_tick && flag && cnt_q != LIM)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign trip = (cnt_q == LIM);

endmodule

// File: rtl/psup_ovp_filter.sv
// Over-voltage qualification over consecutive tick samples.
module psup_ovp_filter #(
    parameter int TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic ovp_raw,
    output logic qualified
);
    generate
        if (TICKS <= 1) begin : g_single
            logic seen_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    seen_q <= 1'b0;
                else if (ms_tick)
                    seen_q <= ovp_raw;
            end
            assign qualified = seen_q;
        end else begin : g_count
            localparam int PW = $clog2(TICKS + 1);
            localparam logic [PW-1:0] FULL = PW'(TICKS);
            logic [PW-1:0] run_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    run_q <= '0;
                else if (ms_tick) begin
                    if (!ovp_raw)
                        run_q <= '0;
                    else if (run_q != FULL)
                        run_q <= run_q + 1'b1;
                end
            end
            assign qualified = (run_q == FULL);
        end
    endgenerate

endmodule

// File: rtl/psup_softstart.sv
// Soft-start step counter: cleared while idle, advances per tick while the
// ramp runs, holds full scale afterwards.
module psup_softstart #(
    parameter int SS_MS = 4,
    parameter int SSW   = $clog2(SS_MS + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           advance,
    input  logic           ms_tick,
    output logic [SSW-1:0] step,
    output logic           done
);
    localparam logic [SSW-1:0] FULL = SSW'(SS_MS);

    logic [SSW-1:0] step_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            step_q <= '0;
        else if (clear)
            step_q <= '0;
        else if (advance && ms_tick && step_q != FULL)
            step_q <= step_q + 1'b1;
    end

    assign step = step_q;
    assign done = (step_q == FULL);

endmodule

// File: rtl/pwr_prot_seq.sv
module pwr_prot_seq
    import psup_pkg::*;
#(
    parameter int SS_MS     = 4,
    parameter int OVL_MS    = 50,
    parameter int OVP_TICKS = 4,
    parameter int SSW       = $clog2(SS_MS + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ms_tick,
    input  logic           cycle_end,
    input  logic           vcc_start,
    input  logic           vcc_stop,
    input  logic           vcc_ovp,
    input  logic           ilim_hit,
    input  logic           over_temp,
    input  logic           latch_opt,
    output logic           drive_en,
    output logic           ss_active,
    output logic [SSW-1:0] ss_step,
    output logic           latched_o
);
    psup_state_e state_q, state_d;

    logic driving;
    logic ovl_trip;
    logic ovp_q;
    logic ss_done;

    assign driving = (state_q == ST_SOFT) || (state_q == ST_RUN);

    psup_ovl_timer #(.LIMIT(OVL_MS)) u_ovl (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (driving),
        .ms_tick   (ms_tick),
        .cycle_end (cycle_end),
        .ilim_hit  (ilim_hit),
        .trip      (ovl_trip)
    );

    psup_ovp_filter #(.TICKS(OVP_TICKS)) u_ovp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ms_tick   (ms_tick),
        .ovp_raw   (vcc_ovp),
        .qualified (ovp_q)
    );

    psup_softstart #(.SS_MS(SS_MS), .SSW(SSW)) u_ss (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!driving),
        .advance (state_q == ST_SOFT),
        .ms_tick (ms_tick),
        .step    (ss_step),
        .done    (ss_done)
    );

    // Next-state decision
    always_comb begin
        state_d = state_q;
        if (ovp_q && state_q != ST_LATCH) begin
            state_d = ST_LATCH;
        end else begin
            unique case (state_q)
                ST_WAIT_ON: begin
                    if (vcc_start && !vcc_stop)
                        state_d = ST_SOFT;
                end
                ST_SOFT, ST_RUN: begin
                    if (vcc_stop)
                        state_d = ST_WAIT_ON;
                    else if (ovl_trip)
                        state_d = latch_opt ? ST_LATCH : ST_HIC_DRAIN1;
                    else if (over_temp)
                        state_d = ST_THERM;
                    else if (state_q == ST_SOFT && ss_done)
                        state_d = ST_RUN;
                end
                ST_THERM: begin
                    if (vcc_stop)
                        state_d = ST_WAIT_ON;
                    else if (!over_temp)
                        state_d = ST_SOFT;
                end
                ST_HIC_DRAIN1: begin
                    if (vcc_stop)
                        state_d = ST_HIC_SKIP;
                end
                ST_HIC_SKIP: begin
                    if (vcc_start && !vcc_stop)
                        state_d = ST_HIC_DRAIN2;
                end
                ST_HIC_DRAIN2: begin
                    if (vcc_stop)
                        state_d = ST_WAIT_ON;
                end
                ST_LATCH: begin
                    state_d = ST_LATCH;
                end
                default: state_d = ST_WAIT_ON;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_WAIT_ON;
        else
            state_q <= state_d;
    end

    // Outputs
    always_comb begin
        drive_en  = 1'b0;
        ss_active = 1'b0;
        latched_o = 1'b0;
        unique case (state_q)
            ST_SOFT: begin
                drive_en  = 1'b1;
                ss_active = 1'b1;
            end
            ST_RUN:   drive_en  = 1'b1;
            ST_LATCH: latched_o = 1'b1;
            ST_WAIT_ON, ST_THERM, ST_HIC_DRAIN1,
            ST_HIC_SKIP, ST_HIC_DRAIN2: begin
                drive_en = 1'b0;
            end
            default: drive_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/psup_checker.sv
module psup_checker #(
    parameter int SS_MS = 4,
    parameter int SSW   = $clog2(SS_MS + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           vcc_stop,
    input logic           over_temp,
    input logic           drive_en,
    input logic           ss_active,
    input logic [SSW-1:0] ss_step,
    input logic           latched_o
);
    localparam logic [SSW-1:0] FULL = SSW'(SS_MS);

    p_stop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en && vcc_stop) |=> !drive_en);

    p_ss_begin_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_en) |-> (ss_active && ss_step == '0));

    p_ss_ceiling_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ss_step <= FULL);

    p_ss_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ss_active |-> drive_en);

    p_latch_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        latched_o |-> !drive_en);

    p_latch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        latched_o |=> latched_o);

    p_hot_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en && over_temp) |=> !drive_en);

endmodule

bind pwr_prot_seq psup_checker #(.SS_MS(SS_MS), .SSW(SSW)) u_psup_chk (.*);

// File: tb/pwr_prot_seq_bench.sv
module pwr_prot_seq_bench;
    localparam int SS_MS     = 4;
    localparam int OVL_MS    = 12;
    localparam int OVP_TICKS = 3;
    localparam int SSW       = $clog2(SS_MS + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ms_tick = 1'b0, cycle_end = 1'b0;
    logic vcc_start = 1'b0, vcc_stop = 1'b0, vcc_ovp = 1'b0;
    logic ilim_hit = 1'b0, over_temp = 1'b0, latch_opt = 1'b0;
    logic drive_en, ss_active, latched_o;
    logic [SSW-1:0] ss_step;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    pwr_prot_seq #(.SS_MS(SS_MS), .OVL_MS(OVL_MS), .OVP_TICKS(OVP_TICKS)) u_pwr_prot_seq (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .cycle_end(cycle_end),
        .vcc_start(vcc_start), .vcc_stop(vcc_stop), .vcc_ovp(vcc_ovp),
        .ilim_hit(ilim_hit), .over_temp(over_temp), .latch_opt(latch_opt),
        .drive_en(drive_en), .ss_active(ss_active), .ss_step(ss_step),
        .latched_o(latched_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic tick();
        ms_tick = 1'b1;
        @(negedge clk);
        ms_tick = 1'b0;
    endtask

    task automatic pulse_start();
        vcc_start = 1'b1;
        @(negedge clk);
        vcc_start = 1'b0;
    endtask

    task automatic pulse_stop();
        vcc_stop = 1'b1;
        @(negedge clk);
        vcc_stop = 1'b0;
        clks(1);
    endtask

    // Expected ramp value for k ticks into a soft-start
    function automatic int ss_expect(input int k);
        return (k > SS_MS) ? SS_MS : k;
    endfunction

    // Double hiccup restart after an auto-recovery overload stop
    task automatic hiccup_restart(input string tag);
        pulse_stop();
        pulse_start();
        clks(1);
        chk({tag, " skipped start keeps drive off"}, int'(drive_en), 0);
        pulse_stop();
        pulse_start();
        chk({tag, " second start drives"}, int'(drive_en), 1);
        chk({tag, " fresh soft-start step"}, int'(ss_step), 0);
    endtask

    initial begin : watchdog
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int cnt_m;
        bit hit_m, early;
        bit il, tk, ce;
        void'($urandom(32'h5EED_0042));

        // Reset state (R8)
        clks(3);
        chk("R8 reset drive", int'(drive_en), 0);
        chk("R8 reset latched", int'(latched_o), 0);
        chk("R2 reset ss_active", int'(ss_active), 0);
        rst_n = 1'b1;
        clks(2);
        chk("R1 no start no drive", int'(drive_en), 0);

        // R1 start, R2 ramp
        pulse_start();
        chk("R1 start drives", int'(drive_en), 1);
        chk("R2 ramp begins active", int'(ss_active), 1);
        chk("R2 ramp begins at zero", int'(ss_step), 0);
        for (int k = 1; k <= SS_MS; k++) begin
            tick();
            chk("R2 ramp step", int'(ss_step), ss_expect(k));
        end
        chk("R2 still active at full", int'(ss_active), 1);
        clks(1);
        chk("R2 ramp ends", int'(ss_active), 0);
        tick(); tick();
        chk("R2 saturates", int'(ss_step), ss_expect(SS_MS + 2));

        // R1 stop
        vcc_stop = 1'b1;
        @(negedge clk);
        chk("R1 stop removes drive", int'(drive_en), 0);
        vcc_stop = 1'b0;
        clks(1);
        pulse_start();
        chk("R1 restart drives", int'(drive_en), 1);

        // R4 clean cycle clears count, then R3 trip (auto-recovery)
        latch_opt = 1'b0;
        ilim_hit = 1'b1;
        for (int k = 0; k < OVL_MS - 1; k++) tick();
        ilim_hit = 1'b0;
        cycle_end = 1'b1; @(negedge clk);
        cycle_end = 1'b0; @(negedge clk);
        cycle_end = 1'b1; @(negedge clk);
        cycle_end = 1'b0;
        ilim_hit = 1'b1;
        for (int k = 0; k < OVL_MS - 1; k++) tick();
        clks(1);
        chk("R4 cleared count prevents trip", int'(drive_en), 1);
        tick();
        chk("R3 not yet stopped at limit edge", int'(drive_en), 1);
        ilim_hit = 1'b0;
        clks(1);
        chk("R3 overload stops drive", int'(drive_en), 0);
        chk("R6 auto-recovery not latched", int'(latched_o), 0);
        hiccup_restart("R6");

        // R3 random hit/tick/cycle patterns against a count model
        for (int run = 0; run < 6; run++) begin
            cnt_m = 0; hit_m = 1'b0; early = 1'b0;
            for (int i = 0; i < 2000; i++) begin
                if (drive_en !== 1'b1) early = 1'b1;
                il = (($urandom % 8) != 0);
                tk = (($urandom % 2) == 1);
                ce = (($urandom % 4) == 0);
                ilim_hit = il; ms_tick = tk; cycle_end = ce;
                if (ce && !hit_m && !il) cnt_m = 0;
                else if (tk && (hit_m || il) && cnt_m < OVL_MS) cnt_m++;
                if (ce) hit_m = il; else if (il) hit_m = 1'b1;
                @(negedge clk);
                if (cnt_m == OVL_MS) break;
            end
            ilim_hit = 1'b0; ms_tick = 1'b0; cycle_end = 1'b0;
            chk("R3 random no early stop", int'(early), 0);
            chk("R3 random model reached limit", cnt_m, OVL_MS);
            clks(1);
            chk("R3 random trip stops drive", int'(drive_en), 0);
            hiccup_restart("R6 random");
        end

        // R5 latch option, R8 latch holds
        latch_opt = 1'b1;
        ilim_hit = 1'b1;
        for (int k = 0; k < OVL_MS; k++) tick();
        ilim_hit = 1'b0;
        clks(1);
        chk("R5 overload latches", int'(latched_o), 1);
        chk("R5 latched no drive", int'(drive_en), 0);
        pulse_stop(); pulse_start(); pulse_stop(); pulse_start();
        over_temp = 1'b1; clks(2); over_temp = 1'b0; clks(2);
        chk("R8 supply cycling keeps latch", int'(latched_o), 1);
        chk("R8 supply cycling keeps drive off", int'(drive_en), 0);
        rst_n = 1'b0; clks(2); rst_n = 1'b1; clks(1);
        chk("R8 reset releases latch", int'(latched_o), 0);
        latch_opt = 1'b0;
        pulse_start();
        chk("R8 fresh start after reset", int'(drive_en), 1);

        // R7 over-voltage filter
        vcc_ovp = 1'b1;
        for (int k = 0; k < OVP_TICKS - 1; k++) tick();
        vcc_ovp = 1'b0; tick();
        vcc_ovp = 1'b1;
        for (int k = 0; k < OVP_TICKS - 1; k++) tick();
        clks(2);
        chk("R7 broken run no latch", int'(latched_o), 0);
        chk("R7 broken run keeps drive", int'(drive_en), 1);
        tick();
        vcc_ovp = 1'b0;
        clks(1);
        chk("R7 qualified ovp latches", int'(latched_o), 1);
        chk("R7 qualified ovp stops drive", int'(drive_en), 0);
        rst_n = 1'b0; clks(2); rst_n = 1'b1; clks(1);

        // R7 from idle
        vcc_ovp = 1'b1;
        for (int k = 0; k < OVP_TICKS; k++) tick();
        vcc_ovp = 1'b0;
        clks(1);
        chk("R7 ovp latches from idle", int'(latched_o), 1);
        rst_n = 1'b0; clks(2); rst_n = 1'b1; clks(1);

        // R9 over-temperature
        pulse_start();
        for (int k = 0; k < SS_MS + 1; k++) tick();
        over_temp = 1'b1;
        @(negedge clk);
        chk("R9 hot stops drive", int'(drive_en), 0);
        tick(); tick();
        chk("R9 stays off while hot", int'(drive_en), 0);
        over_temp = 1'b0;
        @(negedge clk);
        chk("R9 cool resumes drive", int'(drive_en), 1);
        chk("R9 resumes with ramp", int'(ss_active), 1);
        chk("R9 ramp from zero", int'(ss_step), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule